// File: doc/BRIEF.md
# Exception Priority Arbiter

This block sits beside a CPU sequencer and decides which exception starts next. Five sources compete for it: reset, trace, direct power-mode transition, interrupt and software trap. Each request is caught in a pending flag. A fixed priority then picks at most one exception per clock, and the block reports that choice as a one-hot vector together with a one-cycle start pulse. Trace and interrupt are only taken when an instruction completes. Reset, direct transition and trap are taken on any cycle in which the CPU is running.

Some sources are suppressed in certain cases. When the completing instruction is a return-from-exception, no trace is taken at that boundary. When it is a control-register modify, no interrupt is taken at that boundary. The first boundary after reset handling also takes no interrupt. A request that is blocked stays pending and can win at a later boundary.

The reset pin is active low. It passes through a two-flop synchronizer, and the synchronized level also serves as the block's own reset. While the pin is low the CPU is held. Reset handling starts on the synchronized rising edge of the pin, or on a watchdog overflow pulse. All interfaces are plain control pins. The start pulse is a notification, so the block cannot stall and no back-pressure rules apply.

Top module: `exc_arbiter`

## Requirements
- R1: While `res_pin_n` is low, `reset_hold` is 1 from the same instant and no start is issued. Trap and other requests made during the hold are discarded, and every pending flag is cleared.
- R2: After `res_pin_n` rises, the reset exception (`exc_accept` = 5'b00001) is reported after the third rising clock edge. A `wdt_ovf` pulse reports it one edge after being sampled.
- R3: The fixed priority is reset (bit 0), trace (bit 1), direct transition (bit 2), interrupt (bit 3), trap (bit 4). Only one exception starts per cycle, and the losing requests stay pending.
- R4: A trace (5'b00010) is accepted at an instruction boundary (`insn_done`=1) only when `trace_en`=1 and `icm` equals 2'b10.
- R5: No trace is accepted at a boundary whose completing instruction carries `insn_rte`=1.
- R6: An interrupt (5'b01000) is accepted only at a boundary, and not at a boundary with `insn_ccr_mod`=1. A request seen at any other time stays pending until a boundary where it is allowed.
- R7: At the first boundary after reset handling, no interrupt is accepted. A request made there stays pending for the next boundary.
- R8: Direct transition (5'b00100) and trap (5'b10000) requests are accepted on any running cycle, one edge after being sampled, when no higher source wins.
- R9: `exc_start` is high for exactly the cycles in which `exc_accept` has one bit set. `exc_accept` is zero otherwise.
- R10: Starting the reset exception discards every other pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_pin_n | input | 1 | Asynchronous active-low reset pin |
| wdt_ovf | input | 1 | Watchdog overflow pulse, synchronous |
| trace_en | input | 1 | Trace enable bit |
| icm | input | 2 | Interrupt control mode, trace allowed in mode 2'b10 |
| insn_done | input | 1 | Instruction or exception handling completes this cycle |
| insn_rte | input | 1 | Completing instruction is a return-from-exception |
| insn_ccr_mod | input | 1 | Completing instruction modifies the control register |
| irq_req | input | 1 | Interrupt request from the interrupt controller |
| trap_strobe | input | 1 | Trap instruction executed |
| dtr_event | input | 1 | Direct power-mode transition event |
| exc_accept | output | 5 | One-hot accepted exception: bit0 reset, bit1 trace, bit2 direct transition, bit3 interrupt, bit4 trap |
| exc_start | output | 1 | Single-cycle start pulse |
| reset_hold | output | 1 | CPU held in reset state |

## Verification
The assertions check on every running cycle that:
- a start carries exactly one accepted bit;
- the grant never has more than one bit and never a bit that was not requested;
- trace and interrupt starts follow a sampled boundary in the allowed mode, without the return-from-exception or control-register tag.

Only the bench scenarios can show the behaviours that span many cycles and are lost at reset:
- a losing or blocked request survives until a later boundary;
- the first boundary after reset drops interrupts;
- the exact latency through the pin synchronizer.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NSRC = 5;
  localparam int IDX_RST = 0;
  localparam int IDX_TRC = 1;
  localparam int IDX_DTR = 2;
  localparam int IDX_IRQ = 3;
  localparam int IDX_TRP = 4;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pin_n,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] shift_q;
  logic              level_d;

  // Assert asynchronously with the pin, release through the chain.
  always_ff @(posedge clk or negedge pin_n) begin
    if (!pin_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign level = shift_q[STAGES-1];

  always_ff @(posedge clk or negedge pin_n) begin
    if (!pin_n) level_d <= 1'b0;
    else        level_d <= level;
  end

  assign rise = level & ~level_d;
endmodule

// File: rtl/exc_pending.sv
module exc_pending #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         clr_all,
  input  logic [N-1:0] set,
  input  logic [N-1:0] take,
  output logic [N-1:0] eff
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (clr_all) flag_q <= 1'b0;
      else         flag_q <= (flag_q | set[i]) & ~take[i];
    end
    // A fresh request competes in the cycle it arrives.
    assign eff[i] = flag_q | set[i];
  end
endmodule

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    assert_grant_onehot_R3: assert ($onehot0(grant));
    assert_grant_requested_R3: assert ((grant & ~req) == '0);
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                ICM_W       = 2,
  parameter logic [ICM_W-1:0]  TRACE_MODE  = ICM_W'(2)
) (
  input  logic             clk,
  input  logic             res_pin_n,
  input  logic             wdt_ovf,
  input  logic             trace_en,
  input  logic [ICM_W-1:0] icm,
  input  logic             insn_done,
  input  logic             insn_rte,
  input  logic             insn_ccr_mod,
  input  logic             irq_req,
  input  logic             trap_strobe,
  input  logic             dtr_event,
  output logic [NSRC-1:0]  exc_accept,
  output logic             exc_start,
  output logic             reset_hold
);
  logic     run_s;
  logic     run_rise;
  src_vec_t set_v;
  src_vec_t eff_v;
  src_vec_t elig_v;
  src_vec_t grant_v;
  src_vec_t acc_q;
  logic     post_rst_q;
  logic     clr_all;

  exc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .pin_n (res_pin_n),
    .level (run_s),
    .rise  (run_rise)
  );

  assign reset_hold = ~run_s;

  always_comb begin
    set_v          = '0;
    set_v[IDX_RST] = run_rise | wdt_ovf;
    set_v[IDX_TRC] = insn_done & trace_en & (icm == TRACE_MODE) & ~insn_rte;
    set_v[IDX_DTR] = dtr_event;
    set_v[IDX_IRQ] = irq_req;
    set_v[IDX_TRP] = trap_strobe;
  end

  assign clr_all = ~run_s | grant_v[IDX_RST];

  exc_pending #(.N(NSRC)) u_pend (
    .clk     (clk),
    .clr_all (clr_all),
    .set     (set_v),
    .take    (grant_v),
    .eff     (eff_v)
  );

  always_comb begin
    elig_v          = eff_v;
    elig_v[IDX_TRC] = eff_v[IDX_TRC] & insn_done;
    elig_v[IDX_IRQ] = eff_v[IDX_IRQ] & insn_done & ~insn_ccr_mod & ~post_rst_q;
    if (!run_s) elig_v = '0;
  end

  exc_prio_enc #(.N(NSRC)) u_enc (
    .req   (elig_v),
    .grant (grant_v)
  );

  always_ff @(posedge clk) begin
    if (!run_s) begin
      acc_q      <= '0;
      post_rst_q <= 1'b0;
    end else begin
      acc_q <= grant_v;
      if (grant_v[IDX_RST])  post_rst_q <= 1'b1;
      else if (insn_done)    post_rst_q <= 1'b0;
    end
  end

  assign exc_accept = acc_q & {NSRC{run_s}};
  assign exc_start  = |exc_accept;

  assert_start_onehot_R9: assert property (@(posedge clk) disable iff (!run_s)
    exc_start |-> $countones(exc_accept) == 1);

  assert_irq_at_boundary_R6: assert property (@(posedge clk) disable iff (!run_s)
    exc_accept[IDX_IRQ] |-> $past(insn_done) && !$past(insn_ccr_mod));

  assert_trace_mode_R4: assert property (@(posedge clk) disable iff (!run_s)
    exc_accept[IDX_TRC] |-> $past(insn_done) && $past(trace_en) && ($past(icm) == TRACE_MODE));

  assert_no_trace_after_rte_R5: assert property (@(posedge clk) disable iff (!run_s)
    exc_accept[IDX_TRC] |-> !$past(insn_rte));
endmodule

// File: tb/tb_exc_arbiter.sv
module tb_exc_arbiter;
  logic       clk = 1'b0;
  logic       res_pin_n = 1'b0;
  logic       wdt_ovf = 1'b0, trace_en = 1'b0;
  logic [1:0] icm = 2'b00;
  logic       insn_done = 1'b0, insn_rte = 1'b0, insn_ccr_mod = 1'b0;
  logic       irq_req = 1'b0, trap_strobe = 1'b0, dtr_event = 1'b0;
  logic [4:0] exc_accept;
  logic       exc_start, reset_hold;

  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];

  localparam logic [4:0] E_NONE = 5'b00000, E_RST = 5'b00001, E_TRC = 5'b00010,
                         E_DTR = 5'b00100, E_IRQ = 5'b01000, E_TRP = 5'b10000;

  always #2.5 clk = ~clk;

  exc_arbiter dut (
    .clk(clk), .res_pin_n(res_pin_n), .wdt_ovf(wdt_ovf), .trace_en(trace_en),
    .icm(icm), .insn_done(insn_done), .insn_rte(insn_rte), .insn_ccr_mod(insn_ccr_mod),
    .irq_req(irq_req), .trap_strobe(trap_strobe), .dtr_event(dtr_event),
    .exc_accept(exc_accept), .exc_start(exc_start), .reset_hold(reset_hold)
  );

  // Monitor: compares each registered result against the scoreboard.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (exc_accept !== e || exc_start !== (|e)) begin
        n_bad++;
        $display("FAIL %s accept=%b start=%b expected accept=%b start=%b",
                 t, exc_accept, exc_start, e, |e);
      end
    end
  end

  // Driver: one cycle of stimulus, expected result pushed for the monitor.
  task automatic go(input logic done, input logic rte, input logic ccr,
                    input logic irq, input logic trap, input logic dtr,
                    input logic wdt, input logic [4:0] exp, input string tag);
    insn_done = done; insn_rte = rte; insn_ccr_mod = ccr;
    irq_req = irq; trap_strobe = trap; dtr_event = dtr; wdt_ovf = wdt;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    {insn_done, insn_rte, insn_ccr_mod, irq_req, trap_strobe, dtr_event, wdt_ovf} = '0;
  endtask

  task automatic chk_hold(input logic exp, input string tag);
    n_chk++;
    if (reset_hold !== exp) begin
      n_bad++;
      $display("FAIL %s reset_hold=%b expected %b", tag, reset_hold, exp);
    end
  endtask

  task automatic release_pin();
    res_pin_n = 1'b1;
    go(0,0,0,0,0,0,0, E_NONE, "R2 sync stage 1");
    go(0,0,0,0,0,0,0, E_NONE, "R2 sync stage 2");
    go(0,0,0,0,0,0,0, E_RST,  "R2 pin rise");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_hold(1'b1, "R1 hold at start");
    go(0,0,0,0,1,0,0, E_NONE, "R1 trap ignored in hold");
    go(0,0,0,0,0,1,0, E_NONE, "R1 dtr ignored in hold");
    release_pin();
    chk_hold(1'b0, "R1 hold released");

    // R7: first boundary after reset drops interrupt; it stays pending.
    go(1,0,0,1,0,0,0, E_NONE, "R7 irq blocked after reset");
    go(1,0,0,0,0,0,0, E_IRQ,  "R7 irq at next boundary");

    // R4 / R5: trace
    trace_en = 1'b1; icm = 2'b10;
    go(1,0,0,0,0,0,0, E_TRC,  "R4 trace mode 2");
    go(1,1,0,0,0,0,0, E_NONE, "R5 no trace after rte");
    go(0,0,0,0,0,0,0, E_NONE, "R4 no trace off boundary");
    icm = 2'b00;
    go(1,0,0,0,0,0,0, E_NONE, "R4 no trace mode 0");
    icm = 2'b10;

    // R3: trace beats interrupt, interrupt kept
    go(1,0,0,1,0,0,0, E_TRC,  "R3 trace over irq");
    trace_en = 1'b0;
    go(1,0,0,0,0,0,0, E_IRQ,  "R3 irq kept pending");

    // R6: boundary gating and control-register modify
    go(0,0,0,1,0,0,0, E_NONE, "R6 irq off boundary");
    go(0,0,0,0,0,0,0, E_NONE, "R6 irq waits");
    go(1,0,1,0,0,0,0, E_NONE, "R6 irq blocked by ccr modify");
    go(1,0,0,0,0,0,0, E_IRQ,  "R6 irq taken");

    // R8 / R3: trap and direct transition off boundary
    go(0,0,0,0,1,0,0, E_TRP,  "R8 trap any cycle");
    go(0,0,0,0,1,1,0, E_DTR,  "R3 dtr over trap");
    go(0,0,0,0,0,0,0, E_TRP,  "R3 trap kept pending");
    go(0,0,0,0,0,1,0, E_DTR,  "R8 dtr any cycle");

    // R10 / R2: watchdog reset discards pending interrupt
    go(0,0,0,1,0,0,0, E_NONE, "R10 irq latched");
    go(0,0,0,0,0,0,1, E_RST,  "R2 watchdog reset");
    go(1,0,0,0,0,0,0, E_NONE, "R7 boundary after watchdog");
    go(1,0,0,0,0,0,0, E_NONE, "R10 pending irq discarded");

    // R1: pin low mid-run clears pending flags
    go(0,0,0,1,0,0,0, E_NONE, "R1 irq latched before hold");
    res_pin_n = 1'b0;
    #1;
    chk_hold(1'b1, "R1 hold is immediate");
    @(negedge clk);
    go(0,0,0,0,0,0,0, E_NONE, "R1 no start in hold");
    go(1,0,0,0,0,0,0, E_NONE, "R1 no start in hold");
    release_pin();
    go(1,0,0,0,0,0,0, E_NONE, "R7 first boundary");
    go(1,0,0,0,0,0,0, E_NONE, "R1 irq cleared by hold");

    // R3 / R9: trace and trap at one boundary
    trace_en = 1'b1;
    go(1,0,0,0,1,0,0, E_TRC,  "R9 single start trace");
    go(0,0,0,0,0,0,0, E_TRP,  "R9 trap next cycle");
    go(0,0,0,0,0,0,0, E_NONE, "R9 idle no start");

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule